// File: doc/BRIEF.md
# Conversion and Auto Power-Down Sequencer

This block sequences a successive-approximation converter. It moves the track/hold into hold when a conversion starts. It then searches the result one bit at a time, from the most significant bit down, using a DAC trial code and a comparator input. When the search ends, it returns the track/hold to track and publishes the result with a one-cycle valid strobe.

A conversion starts on a low level of the active-low convert-start pin that lasts at least a minimum width, or on a software start pulse. At the end of every conversion the sequencer looks at the pin. If the pin is still low, the block powers down. If it is high, the block stays powered and enforces an acquisition interval before it accepts the next start.

A power-down is partial when the internal reference is in use, because that reference stays alive. It is full when an external reference is selected. Wake-up comes from a rising edge of the pin or from a software start, and is followed by a power-up delay. A start that arrives while the block is converting, acquiring or powering up is rejected and recorded in a sticky error flag. Every duration is a cycle-count parameter.

Top module: `conv_sequencer`

## Requirements
- R1: After reset `hold_o`=0, `valid_o`=0, `result_o`=0, `err_o`=0 and `pwr_mode_o`=2'b00 (fully powered, idle, tracking).
- R2: In idle, a conversion starts on the third clock edge after `cnv_n_i` falls, provided it stays low for at least MIN_LOW_CYC sampled edges. A conversion also starts on the edge that samples `sw_start_i` high. A low pulse sampled at fewer edges starts nothing.
- R3: `hold_o` stays high for exactly RES_W*STEP_CYC cycles. The bench's comparator answers `cmp_i`=1 when the trial code `dac_o` is at or below the input. Bits are decided from the MSB down: a bit is kept when `cmp_i`=1 and cleared when `cmp_i`=0, and the result is the input code.
- R4: On the edge that ends a conversion, the block powers down if the registered pin level is low. If the level is high, the block stays powered (`pwr_mode_o`=2'b00).
- R5: `pwr_mode_o` encodes 2'b00 as powered, 2'b01 as partial power-down (`ext_ref_i`=0) and 2'b10 as full power-down (`ext_ref_i`=1). `ref_on_o` is high only when `ext_ref_i`=0.
- R6: In power-down, a rising edge of `cnv_n_i` or a sampled `sw_start_i` enters power-up. Power-up begins two edges after the pin rises, or on the same edge for the software start, and starts no conversion. A start is accepted no earlier than PWRUP_CYC edges after power-up begins.
- R7: After a conversion that stays powered, a start is accepted no earlier than ACQ_CYC edges after the conversion ends.
- R8: A start during conversion, acquisition or power-up is rejected: no hold results, and `err_o` is set until reset.
- R9: `sw_pdn_i` sampled high in idle powers the block down on that edge.
- R10: `valid_o` is high for one cycle, on the cycle `hold_o` falls, with `result_o` valid from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_n_i | input | 1 | Convert-start pin, active low |
| sw_start_i | input | 1 | Software convert-start pulse |
| sw_pdn_i | input | 1 | Software power-down request |
| ext_ref_i | input | 1 | 1 selects the external reference |
| cmp_i | input | 1 | Comparator: input at or above the trial code |
| dac_o | output | RES_W | Trial code for the DAC |
| hold_o | output | 1 | Track/hold in hold |
| result_o | output | RES_W | Last conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| pwr_mode_o | output | 2 | Power state: 00 on, 01 partial, 10 full |
| ref_on_o | output | 1 | Internal reference enable |
| err_o | output | 1 | Sticky rejected-start flag |

## Verification
The hardest states to reach are the exact edges at which the acquisition and power-up windows close. A start one edge early must be rejected and one edge later accepted. The bench drives software start pulses at counted offsets from the valid strobe and from the wake pulse to land on both edges. Automatic power-down is reached by holding the pin low through a whole conversion. A pin pulse during the power-up that follows then exercises the rejection path.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_ACQ,
    ST_PDN,
    ST_PUP
  } seq_state_e;

  localparam logic [1:0] PM_ON   = 2'b00;
  localparam logic [1:0] PM_PART = 2'b01;
  localparam logic [1:0] PM_FULL = 2'b10;
endpackage

// File: rtl/cnv_pin_filter.sv
module cnv_pin_filter #(
  parameter int MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic start_o,
  output logic rise_o,
  output logic level_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic pin_q, pin_d;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b1;
      pin_d   <= 1'b1;
      low_cnt <= '0;
    end else begin
      pin_q <= pin_i;
      pin_d <= pin_q;
      if (pin_q) low_cnt <= '0;
      else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end
  end

  // fires once per low pulse, when it has lasted MIN_LOW samples
  assign start_o = !pin_q && (low_cnt == LIM - 1'b1);
  assign rise_o  = pin_q && !pin_d;
  assign level_o = pin_q;
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int W    = 10,
  parameter int STEP = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] code_o,
  output logic         last_o
);
  localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int IW = $clog2(W);
  localparam logic [SW-1:0] STEP_END = SW'(STEP - 1);

  logic          active;
  logic [W-1:0]  trial;
  logic [IW-1:0] idx;
  logic [SW-1:0] step;
  logic [W-1:0]  mask;
  logic [W-1:0]  decided;
  logic          step_end;

  assign mask     = {{(W-1){1'b0}}, 1'b1} << idx;
  assign decided  = cmp_i ? trial : (trial & ~mask);
  assign step_end = (step == STEP_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      trial  <= '0;
      idx    <= '0;
      step   <= '0;
    end else if (init_i) begin
      active <= 1'b1;
      trial  <= {1'b1, {(W-1){1'b0}}};
      idx    <= IW'(W - 1);
      step   <= '0;
    end else if (active) begin
      if (step_end) begin
        step <= '0;
        if (idx == '0) begin
          active <= 1'b0;
          trial  <= decided;
        end else begin
          trial <= decided | (mask >> 1);
          idx   <= idx - 1'b1;
        end
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign trial_o = trial;
  assign code_o  = decided;
  assign last_o  = active && step_end && (idx == '0);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (load_i) cnt <= val_i;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int STEP_CYC    = 2,
  parameter int MIN_LOW_CYC = 2,
  parameter int ACQ_CYC     = 20,
  parameter int PWRUP_CYC   = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnv_n_i,
  input  logic             sw_start_i,
  input  logic             sw_pdn_i,
  input  logic             ext_ref_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             hold_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic [1:0]       pwr_mode_o,
  output logic             ref_on_o,
  output logic             err_o
);
  localparam int TMAX = (ACQ_CYC > PWRUP_CYC) ? ACQ_CYC : PWRUP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] ACQ_LOAD = TW'(ACQ_CYC - 1);
  localparam logic [TW-1:0] PUP_LOAD = TW'(PWRUP_CYC - 1);

  seq_state_e state_q, state_d;
  logic pin_start, pin_rise, pin_level;
  logic start_req, sar_init, sar_last, reject;
  logic tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [RES_W-1:0] sar_code, result_q;
  logic valid_q, err_q;

  cnv_pin_filter #(.MIN_LOW(MIN_LOW_CYC)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (cnv_n_i),
    .start_o (pin_start),
    .rise_o  (pin_rise),
    .level_o (pin_level)
  );

  sar_engine #(.W(RES_W), .STEP(STEP_CYC)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (sar_init),
    .cmp_i   (cmp_i),
    .trial_o (dac_o),
    .code_o  (sar_code),
    .last_o  (sar_last)
  );

  interval_timer #(.CW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign start_req = pin_start | sw_start_i;

  always_comb begin
    state_d  = state_q;
    sar_init = 1'b0;
    reject   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = ACQ_LOAD;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d  = ST_CONV;
          sar_init = 1'b1;
        end else if (sw_pdn_i) begin
          state_d = ST_PDN;
        end
      end
      ST_CONV: begin
        reject = start_req;
        if (sar_last) begin
          if (pin_level) begin
            state_d  = ST_ACQ;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_PDN;
          end
        end
      end
      ST_ACQ, ST_PUP: begin
        // window closes on the edge the timer reads zero
        if (tmr_zero) begin
          if (start_req) begin
            state_d  = ST_CONV;
            sar_init = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          reject = start_req;
        end
      end
      ST_PDN: begin
        if (pin_rise || sw_start_i) begin
          state_d  = ST_PUP;
          tmr_load = 1'b1;
          tmr_val  = PUP_LOAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= sar_last;
      if (sar_last) result_q <= sar_code;
      if (reject) err_q <= 1'b1;
    end
  end

  assign hold_o     = (state_q == ST_CONV);
  assign result_o   = result_q;
  assign valid_o    = valid_q;
  assign err_o      = err_q;
  assign ref_on_o   = !ext_ref_i;
  assign pwr_mode_o = (state_q != ST_PDN) ? PM_ON : (ext_ref_i ? PM_FULL : PM_PART);
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_o,
  input logic             valid_o,
  input logic             err_o,
  input logic             ref_on_o,
  input logic [1:0]       pwr_mode_o,
  input logic [RES_W-1:0] result_o
);
  assert_hold_powered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (pwr_mode_o == 2'b00));

  assert_start_from_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> ($past(pwr_mode_o) == 2'b00));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_at_hold_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!hold_o && $past(hold_o)));

  assert_result_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_partial_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_o == 2'b01) |-> ref_on_o);

  assert_full_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_o == 2'b10) |-> !ref_on_o);

  assert_wake_no_conv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pwr_mode_o) != 2'b00) && (pwr_mode_o == 2'b00)) |-> !hold_o);
endmodule

bind conv_sequencer conv_sequencer_chk #(.RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_o     (hold_o),
  .valid_o    (valid_o),
  .err_o      (err_o),
  .ref_on_o   (ref_on_o),
  .pwr_mode_o (pwr_mode_o),
  .result_o   (result_o)
);

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
  localparam int W    = 10;
  localparam int STEP = 2;
  localparam int MINL = 2;
  localparam int ACQ  = 20;
  localparam int PUP  = 150;
  localparam int NVEC = 8;
  // {input code, started by pin}
  localparam logic [W:0] VEC [NVEC] = '{
    {10'd0,    1'b0}, {10'd1023, 1'b1}, {10'd512, 1'b0}, {10'd511, 1'b1},
    {10'h155,  1'b0}, {10'h2AA,  1'b1}, {10'd1,   1'b0}, {10'd1022, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv_n = 1'b1, sw_start = 1'b0, sw_pdn = 1'b0, ext_ref = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] dac, result;
  logic hold, valid, ref_on, err, cmp;
  logic [1:0] pwr;
  int checks = 0, errors = 0;

  assign cmp = (dac <= vin);
  always #5 clk = ~clk;

  conv_sequencer #(
    .RES_W(W), .STEP_CYC(STEP), .MIN_LOW_CYC(MINL), .ACQ_CYC(ACQ), .PWRUP_CYC(PUP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cnv_n_i(cnv_n), .sw_start_i(sw_start),
    .sw_pdn_i(sw_pdn), .ext_ref_i(ext_ref), .cmp_i(cmp), .dac_o(dac),
    .hold_o(hold), .result_o(result), .valid_o(valid), .pwr_mode_o(pwr),
    .ref_on_o(ref_on), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // returns at the negedge after the conversion ends
  task automatic run_conv(input logic [W-1:0] v, input bit by_pin, input bit keep_low,
                          output int hold_cyc);
    vin = v;
    @(negedge clk);
    if (by_pin) begin
      cnv_n = 1'b0;
      for (int g = 0; g < 20 && !hold; g++) @(negedge clk);
    end else begin
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
    end
    hold_cyc = 0;
    while (hold && hold_cyc < 1000) begin
      hold_cyc++;
      if (by_pin && !keep_low && hold_cyc == 3) cnv_n = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int hc;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold", hold, 0);
    chk("R1 valid", valid, 0);
    chk("R1 result", result, 0);
    chk("R1 err", err, 0);
    chk("R1 pwr", pwr, 0);

    // table walk: R2 start sources, R3 search, R4 stay powered, R10 strobe
    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i][W:1], VEC[i][0], 1'b0, hc);
      chk("R3 hold cycles", hc, W*STEP);
      chk("R10 valid", valid, 1);
      chk("R3 result", result, int'(VEC[i][W:1]));
      chk("R4 powered", pwr, 0);
      @(negedge clk);
      chk("R10 one cycle", valid, 0);
      repeat (ACQ + 2) @(negedge clk);
    end
    chk("R8 no spurious err", err, 0);

    // R2 short pulse ignored
    @(negedge clk);
    cnv_n = 1'b0;
    @(negedge clk);
    cnv_n = 1'b1;
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (hold) seen = 1;
    end
    chk("R2 short pulse", seen, 0);

    // R4/R5 auto power-down, partial with internal reference
    ext_ref = 1'b0;
    run_conv(10'd300, 1'b1, 1'b1, hc);
    chk("R3 pin result", result, 300);
    chk("R4 power down", pwr, 1);
    chk("R5 ref alive", ref_on, 1);
    repeat (5) @(negedge clk);
    chk("R4 stays down", pwr, 1);
    cnv_n = 1'b1;
    @(negedge clk);
    chk("R6 wake latency", pwr, 1);
    @(negedge clk);
    chk("R6 woken", pwr, 0);
    // R8 start during power-up
    cnv_n = 1'b0;
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      if (hold) seen = 1;
    end
    cnv_n = 1'b1;
    chk("R8 no hold in power-up", seen, 0);
    chk("R8 err set", err, 1);
    repeat (PUP + 5) @(negedge clk);
    run_conv(10'd77, 1'b0, 1'b0, hc);
    chk("R6 converts after power-up", result, 77);
    repeat (ACQ + 2) @(negedge clk);

    // R7 acquisition window boundary
    run_conv(10'h155, 1'b0, 1'b0, hc);
    chk("R7 valid", valid, 1);
    repeat (ACQ - 2) @(negedge clk);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R7 early start rejected", hold, 0);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R7 start accepted at window end", hold, 1);
    for (int g = 0; g < 100 && hold; g++) @(negedge clk);
    chk("R7 result", result, 'h155);
    chk("R8 err stays", err, 1);
    repeat (ACQ + 2) @(negedge clk);

    // R9 software power-down, R5 full mode, R6 power-up boundary
    ext_ref = 1'b1;
    vin = 10'd777;
    sw_pdn = 1'b1;
    @(negedge clk);
    sw_pdn = 1'b0;
    chk("R9 sw power down", pwr, 2);
    chk("R5 ref off", ref_on, 0);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R6 sw wake", pwr, 0);
    chk("R6 no conversion on wake", hold, 0);
    repeat (PUP - 2) @(negedge clk);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R6 early start rejected", hold, 0);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R6 start accepted after power-up", hold, 1);
    for (int g = 0; g < 100 && hold; g++) @(negedge clk);
    chk("R6 result", result, 777);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule